// File: doc/BRIEF.md
# Command-Queue I2C Master

This block is an I2C bus master that software drives through a small word-indexed register window. Every byte to go on the wire is queued as a command word in an eight-entry transmit queue: bits 7:0 carry the byte and bit 8 is an end-of-transfer flag. After a start request, the first queued word is the target address, with the 7-bit address in bits 7:1 and the direction in bit 0 (1 read, 0 write). A read is paced by queuing one placeholder word per wanted byte. Each placeholder clocks one byte off the bus into an eight-entry receive queue.

A prescaler turns the system clock into a protocol tick. Four timing fields, counted in ticks, set the SCL low time, the SCL high time, the setup time before START and STOP, and the START hold time. The engine drives SCL and SDA as open-drain enables, where an asserted enable pulls the line low. While SCL is released, the engine waits until it reads SCL high. Sticky event flags record completion, NACKs, arbitration loss and queue misuse, and an interrupt line reports the flags that are not masked.

The engine states are IDLE, START_SU, START_HD, FETCH, BIT_LOW, BIT_HIGH, STOP_LOW, STOP_SU and STOP_HD. The transitions are:
- IDLE to START_SU on a start request when the transmit queue is not empty.
- START_SU to START_HD, and START_HD to FETCH, each when its time has elapsed.
- FETCH to BIT_LOW when a word is available.
- BIT_LOW to BIT_HIGH after the low time.
- BIT_HIGH to BIT_LOW for the next bit.
- BIT_HIGH to FETCH after an acknowledged byte whose word has no end flag.
- BIT_HIGH to STOP_LOW on the end flag or on a NACK.
- BIT_HIGH to IDLE on arbitration loss.
- STOP_LOW to STOP_SU to STOP_HD, then STOP_HD to IDLE.
- Any state to IDLE when the block is not ready.

Register word indices are:
- 1: control. Bit 0 enables the block.
- 2: prescaler.
- 3: event mask.
- 4: queue command. Bit 0 clears both queues; bit 1 requests a start.
- 5: status.
- 6: events.
- 7: data port.
- 8: timing. Bits 7:0 are the low time, 15:8 the high time, 23:16 the setup time and 31:24 the hold time.

Top module: `i2c_cmdq_master`

## Requirements
- R1: After reset, status reads 0x03 (bit0 transmit queue empty, bit1 receive queue empty, bit2 ready, bit3 busy, bit4 transmit full, bit5 receive full), events read 0, irq is low, and both pin enables are deasserted.
- R2: Status bit2 (ready) is 1 exactly when control bit0 is 1 and the prescaler is nonzero; while not ready the engine is idle.
- R3: A write transfer sends the address word and then each data byte MSB first, each followed by an acknowledge bit. A word with bit 8 set is followed by STOP, and then event bit0 (done) sets.
- R4: In a read, each placeholder word makes one received byte appear in the receive queue, which is read in order at the data port. Non-final bytes get ACK. The byte of the word with bit 8 set gets NACK and is followed by STOP.
- R5: An address word with bit 8 set gives a transfer of zero data bytes: address, acknowledge, STOP, done.
- R6: A NACK to the address sets event bit2. The engine then sends STOP, discards the queued words and sets done.
- R7: A NACK to a data byte sets event bit1. The engine then sends STOP, discards the remaining words and sets done.
- R8: If SDA reads low while the engine releases it during an address or write bit, event bit3 sets. Both pins are released, the transmit queue is emptied and the engine goes idle without setting done.
- R9: Writing ones to the event register clears those flags; zero bits leave flags unchanged.
- R10: irq is high exactly when some event flag is set whose mask bit is 0; the mask resets to all ones.
- R11: A data write to a full transmit queue is dropped and sets event bit4. A data read from an empty receive queue sets event bit5.
- R12: Queue command bit0 empties both queues in one cycle and reads back as 0.
- R13: When the transmit queue runs empty mid-transfer without an end flag, the engine holds SCL low and stays busy until another word arrives, then continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 4 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at the data port) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_idx |
| irq | output | 1 | Interrupt, OR of unmasked event flags |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that register strobes are single-cycle and never sampled by the design before reset is released. They also assume that the bus lines only read low when some agent pulls them; no target drives SDA while SCL is high except to acknowledge or to return data. The bench keeps to this by using an open-drain wired-AND of the block, an acknowledging target model that changes SDA only on SCL falling edges, and a separate jammer used solely to provoke arbitration loss. Register accesses in the bench are launched on falling clock edges and last one cycle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_START_SU, ST_START_HD, ST_FETCH, ST_BIT_LOW,
        ST_BIT_HIGH, ST_STOP_LOW, ST_STOP_SU, ST_STOP_HD
    } eng_state_t;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } cmd_word_t;

    localparam logic [3:0] IDX_CTRL = 4'd1;
    localparam logic [3:0] IDX_PRE  = 4'd2;
    localparam logic [3:0] IDX_MASK = 4'd3;
    localparam logic [3:0] IDX_QCMD = 4'd4;
    localparam logic [3:0] IDX_STAT = 4'd5;
    localparam logic [3:0] IDX_EVT  = 4'd6;
    localparam logic [3:0] IDX_DATA = 4'd7;
    localparam logic [3:0] IDX_TIME = 4'd8;

    localparam int NUM_EV  = 6;
    localparam int EV_DONE = 0;
    localparam int EV_DNAK = 1;
    localparam int EV_ANAK = 2;
    localparam int EV_ARB  = 3;
    localparam int EV_OVF  = 4;
    localparam int EV_UNF  = 5;
endpackage

// File: rtl/i2cm_queue.sv
module i2cm_queue #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= din;
    end
endmodule

// File: rtl/i2cm_prescale.sv
module i2cm_prescale #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    assign tick = en && (cnt == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!en || tick)   cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          go,
    input  logic          tx_empty,
    input  cmd_word_t     tx_word,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [7:0]    rx_byte,
    input  logic [TW-1:0] t_low,
    input  logic [TW-1:0] t_high,
    input  logic [TW-1:0] t_su,
    input  logic [TW-1:0] t_hd,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          busy,
    output logic          ev_done,
    output logic          ev_anak,
    output logic          ev_dnak,
    output logic          ev_arb,
    output logic          flush_tx
);
    eng_state_t    state_q, state_d;
    logic [TW-1:0] cnt_q, lim;
    logic [3:0]    bitn_q;
    logic [7:0]    sh_q;
    logic          last_q, is_addr_q, rd_phase_q, rd_req_q;
    logic          cnt_en, elapsed, drive_bit;
    logic          ld_word, shift_en, ack_ok, begin_xfer;

    always_comb begin
        unique case (state_q)
            ST_START_SU, ST_STOP_SU, ST_STOP_HD: lim = t_su;
            ST_START_HD:                         lim = t_hd;
            ST_BIT_HIGH:                         lim = t_high;
            default:                             lim = t_low;
        endcase
    end

    assign cnt_en  = tick && (state_q != ST_BIT_HIGH || scl_i);
    assign elapsed = cnt_en && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim});

    always_comb begin
        if (bitn_q < 4'd8) drive_bit = rd_phase_q ? 1'b1 : sh_q[7];
        else               drive_bit = rd_phase_q ? last_q : 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d    = state_q;
        ld_word    = 1'b0;
        shift_en   = 1'b0;
        ack_ok     = 1'b0;
        begin_xfer = 1'b0;
        rx_push    = 1'b0;
        ev_done    = 1'b0;
        ev_anak    = 1'b0;
        ev_dnak    = 1'b0;
        ev_arb     = 1'b0;
        flush_tx   = 1'b0;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go && !tx_empty) begin
                    begin_xfer = 1'b1;
                    state_d    = ST_START_SU;
                end
                ST_START_SU: if (elapsed) state_d = ST_START_HD;
                ST_START_HD: if (elapsed) state_d = ST_FETCH;
                ST_FETCH: if (!tx_empty) begin
                    ld_word = 1'b1;
                    state_d = ST_BIT_LOW;
                end
                ST_BIT_LOW: if (elapsed) state_d = ST_BIT_HIGH;
                ST_BIT_HIGH: if (elapsed) begin
                    if (bitn_q < 4'd8) begin
                        if (!rd_phase_q && drive_bit && !sda_i) begin
                            ev_arb   = 1'b1;
                            flush_tx = 1'b1;
                            state_d  = ST_IDLE;
                        end else begin
                            shift_en = 1'b1;
                            state_d  = ST_BIT_LOW;
                        end
                    end else if (!rd_phase_q && sda_i) begin
                        ev_anak  = is_addr_q;
                        ev_dnak  = !is_addr_q;
                        flush_tx = 1'b1;
                        state_d  = ST_STOP_LOW;
                    end else begin
                        ack_ok  = 1'b1;
                        rx_push = rd_phase_q;
                        state_d = last_q ? ST_STOP_LOW : ST_FETCH;
                    end
                end
                ST_STOP_LOW: if (elapsed) state_d = ST_STOP_SU;
                ST_STOP_SU:  if (elapsed) state_d = ST_STOP_HD;
                ST_STOP_HD: if (elapsed) begin
                    ev_done = 1'b1;
                    state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            bitn_q     <= '0;
            sh_q       <= '0;
            last_q     <= 1'b0;
            is_addr_q  <= 1'b0;
            rd_phase_q <= 1'b0;
            rd_req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (cnt_en)        cnt_q <= cnt_q + 1'b1;
            if (begin_xfer) begin
                is_addr_q  <= 1'b1;
                rd_phase_q <= 1'b0;
            end
            if (ld_word) begin
                sh_q   <= tx_word.data;
                last_q <= tx_word.last;
                bitn_q <= '0;
                if (is_addr_q) rd_req_q <= tx_word.data[0];
            end
            if (shift_en) begin
                sh_q   <= {sh_q[6:0], sda_i};
                bitn_q <= bitn_q + 1'b1;
            end
            if (ack_ok) begin
                is_addr_q <= 1'b0;
                if (is_addr_q) rd_phase_q <= rd_req_q;
            end
        end
    end

    // outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            ST_START_HD:              sda_oe = 1'b1;
            ST_FETCH, ST_STOP_LOW: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_BIT_LOW: begin
                scl_oe = 1'b1;
                sda_oe = !drive_bit;
            end
            ST_BIT_HIGH:              sda_oe = !drive_bit;
            ST_STOP_SU:               sda_oe = 1'b1;
            default: ;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign tx_pop  = ld_word;
    assign rx_byte = sh_q;
endmodule

// File: rtl/i2c_cmdq_master.sv
module i2c_cmdq_master
    import i2cm_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int PRE_W  = 8,
    parameter int TIME_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_idx,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe
);
    localparam int CW = $clog2(QDEPTH) + 1;
    localparam int TREG_W = 4 * TIME_W;

    logic              en_q;
    logic [PRE_W-1:0]  pre_q;
    logic [NUM_EV-1:0] mask_q, evt_q, evt_set;
    logic [TREG_W-1:0] time_q;
    logic              ready, tick, busy;
    logic              wr_data, rd_data, wr_qcmd, q_clear, go;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    cmd_word_t         tx_word;
    logic              tx_pop, rx_push;
    logic [7:0]        rx_byte, rx_dout;
    logic              ev_done, ev_anak, ev_dnak, ev_arb, eng_flush;

    assign ready   = en_q && (pre_q != '0);
    assign wr_data = reg_wr && reg_idx == IDX_DATA;
    assign rd_data = reg_rd && reg_idx == IDX_DATA;
    assign wr_qcmd = reg_wr && reg_idx == IDX_QCMD;
    assign q_clear = wr_qcmd && reg_wdata[0];
    assign go      = wr_qcmd && reg_wdata[1];

    i2cm_prescale #(.DW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(ready), .div(pre_q), .tick(tick)
    );

    i2cm_queue #(.WIDTH(9), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(q_clear || eng_flush),
        .push(wr_data), .din(reg_wdata[8:0]), .pop(tx_pop),
        .dout(tx_word), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    i2cm_queue #(.WIDTH(8), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(q_clear),
        .push(rx_push), .din(rx_byte), .pop(rd_data),
        .dout(rx_dout), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    i2cm_engine #(.TW(TIME_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(ready), .tick(tick), .go(go),
        .tx_empty(tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .t_low(time_q[TIME_W-1:0]), .t_high(time_q[2*TIME_W-1:TIME_W]),
        .t_su(time_q[3*TIME_W-1:2*TIME_W]), .t_hd(time_q[4*TIME_W-1:3*TIME_W]),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .ev_done(ev_done), .ev_anak(ev_anak), .ev_dnak(ev_dnak),
        .ev_arb(ev_arb), .flush_tx(eng_flush)
    );

    always_comb begin
        evt_set          = '0;
        evt_set[EV_DONE] = ev_done;
        evt_set[EV_DNAK] = ev_dnak;
        evt_set[EV_ANAK] = ev_anak;
        evt_set[EV_ARB]  = ev_arb;
        evt_set[EV_OVF]  = wr_data && tx_full && !q_clear;
        evt_set[EV_UNF]  = rd_data && rx_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pre_q  <= PRE_W'(8);
            mask_q <= '1;
            time_q <= {4{TIME_W'(20)}};
            evt_q  <= '0;
        end else begin
            if (reg_wr && reg_idx == IDX_CTRL) en_q   <= reg_wdata[0];
            if (reg_wr && reg_idx == IDX_PRE)  pre_q  <= reg_wdata[PRE_W-1:0];
            if (reg_wr && reg_idx == IDX_MASK) mask_q <= reg_wdata[NUM_EV-1:0];
            if (reg_wr && reg_idx == IDX_TIME) time_q <= reg_wdata[TREG_W-1:0];
            if (reg_wr && reg_idx == IDX_EVT)
                evt_q <= (evt_q & ~reg_wdata[NUM_EV-1:0]) | evt_set;
            else
                evt_q <= evt_q | evt_set;
        end
    end

    assign irq = |(evt_q & ~mask_q);

    always_comb begin
        unique case (reg_idx)
            IDX_CTRL: reg_rdata = 32'(en_q);
            IDX_PRE:  reg_rdata = 32'(pre_q);
            IDX_MASK: reg_rdata = 32'(mask_q);
            IDX_STAT: reg_rdata = 32'({rx_full, tx_full, busy, ready, rx_empty, tx_empty});
            IDX_EVT:  reg_rdata = 32'(evt_q);
            IDX_DATA: reg_rdata = 32'(rx_dout);
            IDX_TIME: reg_rdata = 32'(time_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
    import i2cm_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int CW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        reg_idx,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [CW-1:0]     tx_cnt,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic              busy,
    input logic              ready,
    input logic              ev_arb,
    input logic              ev_done,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              irq,
    input logic [NUM_EV-1:0] evt_q
);
    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(QDEPTH));

    // R12
    queue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_QCMD && reg_wdata[0]) |=> (tx_empty && rx_empty));

    // R8
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb |=> (!scl_oe && !sda_oe && !busy && tx_empty));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_q != '0));

    // R2
    idle_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !busy);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_EVT && reg_wdata[EV_DONE] && !ev_done) |=> !evt_q[EV_DONE]);
endmodule

bind i2c_cmdq_master i2cm_chk #(.QDEPTH(QDEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .tx_cnt(tx_cnt), .tx_empty(tx_empty),
    .rx_empty(rx_empty), .busy(busy), .ready(ready), .ev_arb(ev_arb),
    .ev_done(ev_done), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .evt_q(evt_q)
);

// File: tb/i2c_cmdq_master_test.sv
module i2c_cmdq_master_test;
    localparam int CYC = 8;
    localparam logic [6:0] SLV = 7'h50;
    localparam logic [3:0] I_CTRL = 4'd1, I_PRE = 4'd2, I_MASK = 4'd3, I_QCMD = 4'd4,
                           I_STAT = 4'd5, I_EVT = 4'd6, I_DATA = 4'd7, I_TIME = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, scl_oe, sda_oe;
    logic        slv_low = 1'b0, jam = 1'b0;
    wire         scl_w = !scl_oe;
    wire         sda_w = !(sda_oe || slv_low || jam);

    int total = 0, fails = 0;
    bit finished = 0;

    always #(CYC/2) clk = ~clk;

    i2c_cmdq_master uut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // target model
    logic       in_x = 0, is_a = 0, rdm = 0, m_nack = 0;
    logic [3:0] bn = 0;
    logic [7:0] sh = 0, txb = 0, rdv = 8'hA5, addr_seen = 0, nack_val = 8'hEE;
    logic [7:0] wlog [8];
    int         wn = 0;

    always @(negedge sda_w) if (scl_w) begin
        in_x = 1; is_a = 1; bn = 0; rdm = 0; slv_low = 0;
    end
    always @(posedge sda_w) if (scl_w) begin
        in_x = 0; slv_low = 0;
    end
    always @(posedge scl_w) if (in_x) begin
        if (bn < 8) begin
            sh = {sh[6:0], sda_w}; bn = bn + 1;
        end else begin
            if (rdm && !is_a) begin
                m_nack = sda_w;
                if (sda_w) in_x = 0;
            end
            is_a = 0; bn = 0;
        end
    end
    always @(negedge scl_w) if (in_x) begin
        if (bn == 8) begin
            if (is_a) begin
                addr_seen = sh;
                if (sh[7:1] == SLV) begin rdm = sh[0]; slv_low = 1; end
                else begin slv_low = 0; in_x = 0; end
            end else if (!rdm) begin
                if (wn < 8) wlog[wn] = sh;
                wn = wn + 1;
                slv_low = (sh != nack_val);
            end else slv_low = 0;
        end else if (rdm && !is_a) begin
            if (bn == 0) begin txb = rdv; rdv = rdv + 1; end
            slv_low = !txb[3'd7 - bn[2:0]];
        end else slv_low = 0;
    end

    task automatic slv_reset();
        wn = 0; rdv = 8'hA5; addr_seen = 0; m_nack = 0;
    endtask

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk); reg_idx = idx; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic brd(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk); reg_idx = idx; reg_rd = 1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            brd(I_STAT, s);
            if (!s[3]) break;
        end
    endtask

    task automatic begin_test();
        slv_reset();
        bwr(I_QCMD, 32'h1);
        bwr(I_EVT, 32'h3F);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        brd(I_STAT, d); check("R1 status", d, 32'h03);
        brd(I_EVT, d);  check("R1 events", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 pins", {30'b0, scl_oe, sda_oe}, 0);
    endtask

    task automatic t_ready();
        logic [31:0] d;
        bwr(I_PRE, 0); bwr(I_CTRL, 1);
        brd(I_STAT, d); check("R2 ready with zero prescaler", {31'b0, d[2]}, 0);
        bwr(I_PRE, 2);
        brd(I_STAT, d); check("R2 ready enabled", {31'b0, d[2]}, 1);
        bwr(I_TIME, 32'h02020202);
    endtask

    task automatic t_write();
        logic [31:0] d;
        begin_test();
        bwr(I_DATA, {SLV, 1'b0}); bwr(I_DATA, 32'h03C); bwr(I_DATA, 32'h181);
        bwr(I_QCMD, 32'h2);
        wait_idle();
        check("R3 address seen", {24'b0, addr_seen}, 32'hA0);
        check("R3 byte count", wn, 2);
        check("R3 byte 0", {24'b0, wlog[0]}, 32'h3C);
        check("R3 byte 1", {24'b0, wlog[1]}, 32'h81);
        brd(I_EVT, d); check("R3 done event", d, 32'h01);
    endtask

    task automatic t_read();
        logic [31:0] d;
        begin_test();
        bwr(I_DATA, {SLV, 1'b1}); bwr(I_DATA, 0); bwr(I_DATA, 0); bwr(I_DATA, 32'h100);
        bwr(I_QCMD, 32'h2);
        wait_idle();
        brd(I_EVT, d); check("R4 done event", d, 32'h01);
        brd(I_DATA, d); check("R4 rx byte 0", d, 32'hA5);
        brd(I_DATA, d); check("R4 rx byte 1", d, 32'hA6);
        brd(I_DATA, d); check("R4 rx byte 2", d, 32'hA7);
        check("R4 final NACK", {31'b0, m_nack}, 1);
        brd(I_STAT, d); check("R4 rx empty", {31'b0, d[1]}, 1);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        begin_test();
        bwr(I_DATA, 32'h1A0); bwr(I_QCMD, 32'h2);
        wait_idle();
        check("R5 address seen", {24'b0, addr_seen}, 32'hA0);
        check("R5 no data", wn, 0);
        brd(I_EVT, d); check("R5 done", d, 32'h01);
    endtask

    task automatic t_addr_nack();
        logic [31:0] d;
        begin_test();
        bwr(I_DATA, 32'h046); bwr(I_DATA, 32'h011); bwr(I_DATA, 32'h122);
        bwr(I_QCMD, 32'h2);
        wait_idle();
        brd(I_EVT, d); check("R6 events", d, 32'h05);
        brd(I_STAT, d); check("R6 tx emptied", {31'b0, d[0]}, 1);
        check("R6 no data", wn, 0);
    endtask

    task automatic t_data_nack();
        logic [31:0] d;
        begin_test();
        bwr(I_DATA, {SLV, 1'b0}); bwr(I_DATA, 32'h011); bwr(I_DATA, 32'h0EE);
        bwr(I_DATA, 32'h022); bwr(I_DATA, 32'h133);
        bwr(I_QCMD, 32'h2);
        wait_idle();
        brd(I_EVT, d); check("R7 events", d, 32'h03);
        check("R7 bytes sent", wn, 2);
        brd(I_STAT, d); check("R7 tx emptied", {31'b0, d[0]}, 1);
    endtask

    task automatic t_stall();
        logic [31:0] d;
        begin_test();
        bwr(I_DATA, {SLV, 1'b0}); bwr(I_QCMD, 32'h2);
        repeat (400) @(negedge clk);
        check("R13 SCL held low", {31'b0, scl_w}, 0);
        brd(I_STAT, d); check("R13 busy", {31'b0, d[3]}, 1);
        bwr(I_DATA, 32'h15A);
        wait_idle();
        check("R13 resumed byte", {24'b0, wlog[0]}, 32'h5A);
        brd(I_EVT, d); check("R13 done", d, 32'h01);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        begin_test();
        jam = 1;
        bwr(I_DATA, {SLV, 1'b0}); bwr(I_DATA, 32'h011); bwr(I_QCMD, 32'h2);
        wait_idle();
        brd(I_EVT, d); check("R8 arbitration event", d, 32'h08);
        brd(I_STAT, d); check("R8 tx emptied", {31'b0, d[0]}, 1);
        check("R8 pins released", {30'b0, scl_oe, sda_oe}, 0);
        jam = 0;
        @(negedge clk);
    endtask

    task automatic t_irq_w1c();
        logic [31:0] d;
        check("R10 masked irq", {31'b0, irq}, 0);
        bwr(I_MASK, 32'h37);
        check("R10 unmasked irq", {31'b0, irq}, 1);
        bwr(I_EVT, 32'h01);
        brd(I_EVT, d); check("R9 zero bits keep", d, 32'h08);
        bwr(I_EVT, 32'h08);
        brd(I_EVT, d); check("R9 ones clear", d, 0);
        check("R10 irq drops", {31'b0, irq}, 0);
        bwr(I_MASK, 32'h3F);
    endtask

    task automatic t_limits();
        logic [31:0] d;
        begin_test();
        for (int i = 0; i < 9; i++) bwr(I_DATA, 32'(i));
        brd(I_STAT, d); check("R11 tx full", {31'b0, d[4]}, 1);
        brd(I_EVT, d);  check("R11 overflow event", d, 32'h10);
        brd(I_QCMD, d); check("R12 reads zero", d, 0);
        bwr(I_QCMD, 32'h1);
        brd(I_STAT, d); check("R12 queues empty", d & 32'h13, 32'h03);
        bwr(I_EVT, 32'h3F);
        brd(I_DATA, d);
        brd(I_EVT, d); check("R11 underflow event", d, 32'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ready();
        t_write();
        t_read();
        t_zero();
        t_addr_nack();
        t_data_nack();
        t_stall();
        t_arb();
        t_irq_w1c();
        t_limits();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(CYC * 190000);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule